// File: doc/BRIEF.md
# Grouped Four-Level Interrupt Priority Controller

This block sits between a handful of peripheral interrupt lines and a small microcontroller core. Each source owns one pending flag. A fixed, parameterised map places every source in one of six groups. Software gives each group one of four priority levels through two byte-wide priority registers. Each of those registers holds one bit of the 2-bit level for every group.

On every cycle the controller finds the group with the highest level that has an enabled pending source. Ties between groups go to a fixed polling order. The controller offers the lowest-indexed pending source of the winning group to the core as a vector index, with a request strobe. A 4-bit in-service record, one bit per level, makes nesting obey the level rules: a request is offered only above the highest level now in service. An acknowledge marks the level as in service and may clear the flag. A return marks the top level as done.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset all four registers read 0x00, no level is in service and irq_req_o is low.
- R2: Address 1 holds bit 0 and address 2 holds bit 1 of the levels. Bit n of each belongs to group n (n = 0..5), so group n's level is {addr2[n], addr1[n]}. Bits 7:6 of both read as zero.
- R3: Address 0 holds the pending flags: bit i is source i for i = 0..4, and bits 7:5 read as zero. A one on irq_set_i[i] sets flag i in the next cycle. If a software write to address 0 lands in the same cycle, the set takes precedence.
- R4: Address 3 holds the source enables in bits 4:0 and the global enable in bit 7, and its other bits read as zero. A source takes part in arbitration only when its flag, its enable and the global enable are all set.
- R5: Among groups with an eligible source, the one with the highest level wins, and irq_lvl_o shows that level.
- R6: Between groups at the same level, the lower group number wins.
- R7: Sources map to groups as follows: source 0 to group 0, sources 1 and 2 to group 2, source 3 to group 1, source 4 to group 5. Groups 3 and 4 are empty. irq_vec_o gives the lowest-indexed eligible source in the winning group.
- R8: irq_req_o is high only when the winning level is strictly above every level now in service. A level equal to or below it is held off.
- R9: irq_ack_i while irq_req_o is high marks irq_lvl_o as in service. It clears the offered source's flag only if that source auto-clears. Sources 1 and 2 auto-clear; sources 0, 3 and 4 do not.
- R10: irq_ret_i removes the highest in-service level. Lower levels stay in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i |
| irq_set_i | input | 5 | Per-source set pulses from peripherals |
| irq_req_o | output | 1 | Interrupt request to the core |
| irq_vec_o | output | 3 | Index of the offered source |
| irq_lvl_o | output | 2 | Level of the offered request |
| irq_ack_i | input | 1 | Core accepts the offered request |
| irq_ret_i | input | 1 | Core returns from the current handler |

## Verification
The hardest state to reach is a stack three levels deep. In it, a non-clearing source stays pending at a level that is already in service. Whether that source is offered again then depends only on which returns have happened. The bench builds this state step by step. It programs distinct levels for three groups, leaves a low-level flag set, and then raises two higher sources one after the other. It acknowledges each one and leaves the top flag set. Returns then peel the levels off one at a time, with the flags and the request checked after each step. Separately, every one of the 4096 priority settings is swept with all sources pending. Every flag and enable pattern is also swept under a fixed priority setting.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int NUM_GRP = 6;
  localparam int LVL_W   = 2;
  localparam int NUM_LVL = 1 << LVL_W;
  localparam int GRP_W   = $clog2(NUM_GRP);

  typedef logic [LVL_W-1:0] lvl_t;

  typedef enum logic [1:0] {
    ADDR_FLAG = 2'd0,
    ADDR_PLO  = 2'd1,
    ADDR_PHI  = 2'd2,
    ADDR_ENA  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/irq_prio_regs.sv
module irq_prio_regs
  import irq_prio_pkg::*;
#(
  parameter int NUM_SRC = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [1:0]         addr_i,
  input  logic [7:0]         wdata_i,
  output logic [7:0]         rdata_o,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] flag_o,
  output logic [NUM_SRC-1:0] en_o,
  output logic               gen_o,
  output lvl_t               grp_lvl_o [NUM_GRP]
);
  logic [NUM_SRC-1:0] flag_q, en_q;
  logic [NUM_GRP-1:0] plo_q, phi_q;
  logic               gen_q;
  logic               unused_wdata;

  assign unused_wdata = ^wdata_i[6:NUM_SRC];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= '0;
      en_q   <= '0;
      gen_q  <= 1'b0;
      plo_q  <= '0;
      phi_q  <= '0;
    end else begin
      // hardware set overrides a same-cycle software write
      if (we_i && addr_i == ADDR_FLAG) flag_q <= wdata_i[NUM_SRC-1:0] | set_i;
      else                             flag_q <= (flag_q & ~clr_i) | set_i;
      if (we_i && addr_i == ADDR_PLO) plo_q <= wdata_i[NUM_GRP-1:0];
      if (we_i && addr_i == ADDR_PHI) phi_q <= wdata_i[NUM_GRP-1:0];
      if (we_i && addr_i == ADDR_ENA) begin
        en_q  <= wdata_i[NUM_SRC-1:0];
        gen_q <= wdata_i[7];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_FLAG: rdata_o[NUM_SRC-1:0] = flag_q;
      ADDR_PLO:  rdata_o[NUM_GRP-1:0] = plo_q;
      ADDR_PHI:  rdata_o[NUM_GRP-1:0] = phi_q;
      ADDR_ENA:  begin
        rdata_o[NUM_SRC-1:0] = en_q;
        rdata_o[7]           = gen_q;
      end
      default:   rdata_o = '0;
    endcase
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_lvl
    assign grp_lvl_o[g] = {phi_q[g], plo_q[g]};
  end

  assign flag_o = flag_q;
  assign en_o   = en_q;
  assign gen_o  = gen_q;
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
  import irq_prio_pkg::*;
#(
  parameter int                     NUM_SRC = 5,
  parameter logic [NUM_SRC*GRP_W-1:0] SRC_GRP = '0,
  localparam int                    SRC_W   = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] pend_i,
  input  lvl_t               grp_lvl_i [NUM_GRP],
  input  logic [NUM_LVL-1:0] isr_i,
  output logic               req_o,
  output logic [SRC_W-1:0]   vec_o,
  output lvl_t               lvl_o
);
  logic [NUM_GRP-1:0] grp_act;
  logic [GRP_W-1:0]   win;
  logic               found, isr_any;
  lvl_t               best, top;

  always_comb begin
    grp_act = '0;
    for (int s = 0; s < NUM_SRC; s++)
      for (int g = 0; g < NUM_GRP; g++)
        if (pend_i[s] && SRC_GRP[s*GRP_W +: GRP_W] == GRP_W'(g)) grp_act[g] = 1'b1;

    // strict compare: on a tie the lower group keeps the slot
    found = 1'b0;
    best  = '0;
    win   = '0;
    for (int g = 0; g < NUM_GRP; g++)
      if (grp_act[g] && (!found || grp_lvl_i[g] > best)) begin
        found = 1'b1;
        best  = grp_lvl_i[g];
        win   = GRP_W'(g);
      end

    vec_o = '0;
    for (int s = NUM_SRC - 1; s >= 0; s--)
      if (pend_i[s] && SRC_GRP[s*GRP_W +: GRP_W] == win) vec_o = SRC_W'(s);

    isr_any = |isr_i;
    top     = '0;
    for (int l = 0; l < NUM_LVL; l++)
      if (isr_i[l]) top = lvl_t'(l);

    req_o = found && (!isr_any || best > top);
    lvl_o = best;
  end
endmodule

// File: rtl/irq_prio_stack.sv
module irq_prio_stack
  import irq_prio_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               push_i,
  input  lvl_t               push_lvl_i,
  input  logic               pop_i,
  output logic [NUM_LVL-1:0] isr_o
);
  logic [NUM_LVL-1:0] isr_q, top_oh;

  always_comb begin
    top_oh = '0;
    for (int l = 0; l < NUM_LVL; l++)
      if (isr_q[l]) top_oh = NUM_LVL'(1) << l;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) isr_q <= '0;
    else isr_q <= (isr_q & ~(pop_i ? top_oh : '0))
                | (push_i ? NUM_LVL'(1) << push_lvl_i : '0);
  end

  assign isr_o = isr_q;
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int                       NUM_SRC  = 5,
  parameter logic [NUM_SRC*GRP_W-1:0] SRC_GRP  = {3'd5, 3'd1, 3'd2, 3'd2, 3'd0},
  parameter logic [NUM_SRC-1:0]       AUTO_CLR = 5'b00110,
  localparam int                      SRC_W    = $clog2(NUM_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [1:0]         reg_addr_i,
  input  logic [7:0]         reg_wdata_i,
  output logic [7:0]         reg_rdata_o,
  input  logic [NUM_SRC-1:0] irq_set_i,
  output logic               irq_req_o,
  output logic [SRC_W-1:0]   irq_vec_o,
  output logic [LVL_W-1:0]   irq_lvl_o,
  input  logic               irq_ack_i,
  input  logic               irq_ret_i
);
  logic [NUM_SRC-1:0] flag, en, pend, clr;
  logic               gen, take;
  logic [NUM_LVL-1:0] isr;
  lvl_t               grp_lvl [NUM_GRP];
  lvl_t               win_lvl;

  assign take = irq_ack_i & irq_req_o;
  assign clr  = take ? ((NUM_SRC'(1) << irq_vec_o) & AUTO_CLR) : '0;
  assign pend = flag & en & {NUM_SRC{gen}};

  irq_prio_regs #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .set_i(irq_set_i), .clr_i(clr),
    .flag_o(flag), .en_o(en), .gen_o(gen), .grp_lvl_o(grp_lvl)
  );

  irq_prio_arbiter #(.NUM_SRC(NUM_SRC), .SRC_GRP(SRC_GRP)) u_arb (
    .pend_i(pend), .grp_lvl_i(grp_lvl), .isr_i(isr),
    .req_o(irq_req_o), .vec_o(irq_vec_o), .lvl_o(win_lvl)
  );

  irq_prio_stack u_stack (
    .clk_i, .rst_ni,
    .push_i(take), .push_lvl_i(win_lvl), .pop_i(irq_ret_i), .isr_o(isr)
  );

  assign irq_lvl_o = win_lvl;
endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk
  import irq_prio_pkg::*;
#(
  parameter int NUM_SRC = 5,
  localparam int SRC_W  = $clog2(NUM_SRC)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] irq_set_i,
  input logic               irq_req_o,
  input logic [SRC_W-1:0]   irq_vec_o,
  input logic [LVL_W-1:0]   irq_lvl_o,
  input logic               irq_ack_i,
  input logic               irq_ret_i,
  input logic [NUM_LVL-1:0] isr_i,
  input logic [NUM_SRC-1:0] flag_i,
  input logic               gen_i
);
  logic unused_vec;
  assign unused_vec = ^irq_vec_o;

  p_set_wins_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|irq_set_i) |=> ((flag_i & $past(irq_set_i)) == $past(irq_set_i)));

  p_gen_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gen_i |-> !irq_req_o);

  p_strictly_above_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> ((isr_i >> irq_lvl_o) == '0));

  p_ack_marks_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_req_o && irq_ack_i) |=> isr_i[$past(irq_lvl_o)]);

  p_ret_pops_one_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ret_i && !irq_ack_i && (|isr_i)) |=>
      ($countones(isr_i) + 1 == $past($countones(isr_i))));
endmodule

bind irq_prio_ctrl irq_prio_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk_i, .rst_ni, .irq_set_i, .irq_req_o, .irq_vec_o, .irq_lvl_o,
  .irq_ack_i, .irq_ret_i, .isr_i(isr), .flag_i(flag), .gen_i(gen)
);

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [4:0] set = '0;
  logic       req, ack = 1'b0, ret = 1'b0;
  logic [2:0] vec;
  logic [1:0] lvl;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  int grp_of [5] = '{0, 2, 2, 1, 5};

  always #2 clk = ~clk;

  irq_prio_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_set_i(set),
    .irq_req_o(req), .irq_vec_o(vec), .irq_lvl_o(lvl),
    .irq_ack_i(ack), .irq_ret_i(ret)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] a, input int exp);
    addr = a; #1;
    chk(tag, int'(rdata), exp);
  endtask

  task automatic pulse_set(input logic [4:0] m);
    @(negedge clk); set = m;
    @(negedge clk); set = '0;
  endtask

  task automatic do_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic do_ret();
    @(negedge clk); ret = 1'b1;
    @(negedge clk); ret = 1'b0;
  endtask

  // expected arbitration computed from the requirement text
  task automatic model(input logic [4:0] fl, input logic [4:0] en, input bit g,
                       input logic [5:0] lo, input logic [5:0] hi, input int top,
                       output bit e_req, output int e_vec, output int e_lvl);
    logic [4:0] pend;
    bit found = 0;
    int best = 0, win = 0;
    pend = g ? (fl & en) : 5'd0;
    for (int gi = 0; gi < 6; gi++) begin
      bit act = 0;
      int l = 2 * int'(hi[gi]) + int'(lo[gi]);
      for (int s = 0; s < 5; s++) if (pend[s] && grp_of[s] == gi) act = 1;
      if (act && (!found || l > best)) begin found = 1; best = l; win = gi; end
    end
    e_vec = 0;
    for (int s = 4; s >= 0; s--) if (pend[s] && grp_of[s] == win) e_vec = s;
    e_req = found && (top < 0 || best > top);
    e_lvl = best;
  endtask

  task automatic cmp(input string tag, input bit e_req, input int e_vec, input int e_lvl);
    chk({tag, " req"}, int'(req), int'(e_req));
    if (e_req) begin
      chk({tag, " vec"}, int'(vec), e_vec);
      chk({tag, " lvl"}, int'(lvl), e_lvl);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    bit e_req; int e_vec, e_lvl;
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 4; a++) rd_chk("R1 reset reg", 2'(a), 0);
    chk("R1 reset req", int'(req), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 priority registers
    wr(2'd1, 8'hFF); rd_chk("R2 lo mask", 2'd1, 8'h3F);
    wr(2'd2, 8'hFF); rd_chk("R2 hi mask", 2'd2, 8'h3F);
    wr(2'd1, 8'h00); wr(2'd2, 8'h00);

    // R3 flags
    wr(2'd0, 8'hFF); rd_chk("R3 flag mask", 2'd0, 8'h1F);
    wr(2'd0, 8'h00); rd_chk("R3 flag clear", 2'd0, 0);
    pulse_set(5'b01000); rd_chk("R3 set pulse", 2'd0, 8'h08);
    @(negedge clk); we = 1'b1; addr = 2'd0; wdata = 8'h00; set = 5'b00100;
    @(negedge clk); we = 1'b0; set = '0;
    rd_chk("R3 set beats write", 2'd0, 8'h04);

    // R4 enables
    wr(2'd0, 8'h1F);
    wr(2'd3, 8'h1F); rd_chk("R4 en readback", 2'd3, 8'h1F);
    chk("R4 global off", int'(req), 0);
    wr(2'd3, 8'hFF); rd_chk("R4 en mask", 2'd3, 8'h9F);
    chk("R4 global on", int'(req), 1);

    // R5 R6 R7 sweep all level settings, all sources pending
    for (int p = 0; p < 4096; p++) begin
      wr(2'd1, 8'(p[5:0]));
      wr(2'd2, 8'(p[11:6]));
      model(5'h1F, 5'h1F, 1'b1, 6'(p[5:0]), 6'(p[11:6]), -1, e_req, e_vec, e_lvl);
      cmp("R5 R6 prio sweep", e_req, e_vec, e_lvl);
    end

    // R4 R7 sweep flags and enables with fixed levels (g0..g5 = 0,1,2,1,2,3)
    wr(2'd1, 8'b101010);
    wr(2'd2, 8'b110100);
    for (int f = 0; f < 32; f++) begin
      wr(2'd0, 8'(f));
      for (int e = 0; e < 64; e++) begin
        wr(2'd3, {e[5], 2'b00, 5'(e[4:0])});
        model(5'(f), 5'(e[4:0]), e[5], 6'b101010, 6'b110100, -1, e_req, e_vec, e_lvl);
        cmp("R4 R7 flag sweep", e_req, e_vec, e_lvl);
      end
    end

    // R8 R9 R10 nesting: g0=1, g2=2, g5=3
    wr(2'd3, 8'h9F);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'b100001);
    wr(2'd2, 8'b100100);
    wr(2'd0, 8'h01);
    cmp("R5 base", 1'b1, 0, 1);
    do_ack();
    chk("R8 equal held", int'(req), 0);
    rd_chk("R9 no autoclear src0", 2'd0, 8'h01);
    pulse_set(5'b00010);
    cmp("R8 nest above", 1'b1, 1, 2);
    do_ack();
    rd_chk("R9 autoclear src1", 2'd0, 8'h01);
    chk("R8 lower held", int'(req), 0);
    pulse_set(5'b10000);
    cmp("R8 nest top", 1'b1, 4, 3);
    do_ack();
    chk("R8 top equal held", int'(req), 0);
    rd_chk("R9 no autoclear src4", 2'd0, 8'h11);
    do_ret();
    cmp("R10 pop reoffers", 1'b1, 4, 3);
    wr(2'd0, 8'h01);
    chk("R10 cleared src4", int'(req), 0);
    do_ret();
    chk("R10 lvl1 still busy", int'(req), 0);
    do_ret();
    cmp("R10 empty reoffers", 1'b1, 0, 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule